// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves single characters over the one shared data wire of an asynchronous IC card. It is half-duplex. A character on the wire is a low start bit, eight data bits and one parity bit, and each bit lasts one elementary time unit (etu). One etu is a set number of pulses on a bit-rate tick input. Two independent controls shape the character. One picks the order of the data bits and the other picks whether bit levels are inverted, so both card conventions and any mix of them can be used.

On receive, the block checks parity. When parity is wrong it pulls the wire low during the error window so the card repeats the character. On transmit, it watches the same window. If the card flags an error, the block resends the character, up to a programmable limit. The wire is open-drain: the block only ever pulls it low and reads it back through a synchronizer. A gated card clock output is also provided.

Top module: `scc_xcvr`

## Requirements
- R1: After reset, tx_ready is 1, line_drive_low is 0, card_clk is 0, and rx_valid, rx_par_err and tx_done are all 0.
- R2: An accepted byte goes out as a start bit (line low), then 8 data bits, then a parity bit. Each bit lasts etu_div ticks. The line is released after the parity bit.
- R3: With cfg_msb_first=0, data bit 0 goes out first. With cfg_msb_first=1, data bit 7 goes out first. Receive uses the same order.
- R4: With cfg_invert=0, a logical 1 is a high line and a logical 0 is a low line. With cfg_invert=1, the levels of the data and parity bits are swapped. For example, 0x3B with both controls at 0 appears as line levels 0,1,1,0,1,1,1,0,0,1 (start bit first, parity bit last).
- R5: With cfg_odd_par=0, the parity bit makes the count of logical ones over data and parity even. With cfg_odd_par=1, it makes that count odd.
- R6: A line that is low 11 etu after the start edge is an error signal. The same character then restarts 14 etu after the previous start edge, up to max_retry extra times. If the last allowed try also sees an error, tx_done comes with tx_fail=1. Otherwise tx_fail=0.
- R7: tx_done is a one-cycle pulse. With cfg_tend_early=0 it comes 12·etu_div+1 clock cycles after the first cycle of the final start bit. With cfg_tend_early=1 it comes 11·etu_div+1 cycles after that cycle.
- R8: Start edges of consecutive characters are at least 12 etu apart. tx_ready stays 0 until that guard time has passed.
- R9: The receiver detects a falling edge and samples each bit in the middle of its etu. For a character with correct parity, it gives a one-cycle rx_valid pulse with the decoded byte.
- R10: For a parity error, rx_par_err pulses and rx_valid does not. The block also pulls the line low from about 10.5 to 11.5 etu after the detected start edge.
- R11: A low pulse that has ended by the middle of the start bit is ignored. It produces no output.
- R12: With cfg_clk_en=1, card_clk toggles on every bit_tick. With cfg_clk_en=0, card_clk is held low.
- R13: The receiver ignores the line while the transmitter is busy or requested. The transmitter does not start while a character is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Bit-rate tick, one pulse per rate step |
| etu_div | input | DIV_W | Ticks per etu (at least 4) |
| cfg_msb_first | input | 1 | Bit order: 0 sends LSB first, 1 sends MSB first |
| cfg_invert | input | 1 | Level inversion of data and parity bits |
| cfg_odd_par | input | 1 | Parity select: 0 even, 1 odd |
| cfg_tend_early | input | 1 | tx_done timing: 0 at 12 etu, 1 at 11 etu |
| cfg_clk_en | input | 1 | Card clock output enable |
| max_retry | input | RETRY_W | Number of resends allowed after an error signal |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_done | output | 1 | Character finished (pulse) |
| tx_fail | output | 1 | Retries used up (pulse, together with tx_done) |
| rx_valid | output | 1 | Received byte valid (pulse) |
| rx_data | output | 8 | Received byte |
| rx_par_err | output | 1 | Received parity error (pulse) |
| line_in | input | 1 | Level read back from the card data line |
| line_drive_low | output | 1 | Pull the card data line low |
| card_clk | output | 1 | Card clock output |

## Verification
The transmit path is tested with the direct setting, the inverse setting, and each of the two controls set alone. A byte such as 0x12 only decodes correctly if the order and inversion paths are separate. Odd parity is tested with 0x00 and 0x80, which separates the parity sense from the data value. Error signals are injected once, to show that a single resend happens 14 etu after the first start, and then on every try with a limit of one, to show the fail outcome. Receive is tested with good frames in several conventions, with a deliberately wrong parity bit, and with a short glitch. These show apart the data path, the error-signal drive and the start-bit recheck.

// File: rtl/scc_pkg.sv
package scc_pkg;
   function automatic logic [7:0] scc_rev8(input logic [7:0] d);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = d[7-i];
      return r;
   endfunction
endpackage

// File: rtl/scc_sync.sv
module scc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= 1'b1;
            else        q <= d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sr <= '1;
            else        sr <= {sr[STAGES-2:0], d};
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/scc_cardclk.sv
module scc_cardclk (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic en,
   output logic card_clk
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    card_clk <= 1'b0;
      else if (!en)  card_clk <= 1'b0;
      else if (tick) card_clk <= ~card_clk;

   a_r12_clk_held_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !card_clk);
endmodule

// File: rtl/scc_tx.sv
module scc_tx
   import scc_pkg::*;
#(
   parameter int DIV_W   = 12,
   parameter int RETRY_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [DIV_W-1:0]   div,
   input  logic               msb_first,
   input  logic               invert,
   input  logic               odd_par,
   input  logic               tend_early,
   input  logic [RETRY_W-1:0] max_retry,
   input  logic               line_s,
   input  logic               rx_busy,
   input  logic               valid,
   input  logic [7:0]         data,
   output logic               ready,
   output logic               busy,
   output logic               drv,
   output logic               done,
   output logic               fail
);
   logic               busy_q, rpt, ffail;
   logic [DIV_W-1:0]   sub;
   logic [3:0]         idx;
   logic [15:0]        frame;
   logic [RETRY_W-1:0] rcnt;
   logic [7:0]         ord;
   logic               par, etu_end, etu_first, err_now, can_retry;

   assign ord       = msb_first ? scc_rev8(data) : data;
   assign par       = (^data) ^ odd_par;
   assign etu_end   = tick && (sub == (div - 1'b1));
   assign etu_first = tick && (sub == '0);
   assign err_now   = ~line_s;
   assign can_retry = (rcnt < max_retry);
   assign ready     = !busy_q && !rx_busy;
   assign busy      = busy_q;
   assign drv       = busy_q && (idx < 4'd10) && !frame[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0; rpt <= 1'b0; ffail <= 1'b0;
         sub <= '0; idx <= '0; frame <= '1; rcnt <= '0;
         done <= 1'b0; fail <= 1'b0;
      end else begin
         done <= 1'b0;
         fail <= 1'b0;
         if (!busy_q) begin
            if (valid && !rx_busy) begin
               busy_q <= 1'b1; sub <= '0; idx <= '0;
               rpt <= 1'b0; ffail <= 1'b0; rcnt <= '0;
               frame <= {6'h3F, par ^ invert, ord ^ {8{invert}}, 1'b0};
            end
         end else if (tick) begin
            if (etu_end) begin
               sub <= '0;
               idx <= idx + 4'd1;
            end else begin
               sub <= sub + 1'b1;
            end
            if (etu_first && idx == 4'd11) begin
               if (err_now && can_retry) rpt <= 1'b1;
               else begin
                  ffail <= err_now;
                  if (tend_early) begin
                     done <= 1'b1;
                     fail <= err_now;
                  end
               end
            end
            if (etu_first && idx == 4'd12 && !rpt) begin
               busy_q <= 1'b0;
               rcnt   <= '0;
               if (!tend_early) begin
                  done <= 1'b1;
                  fail <= ffail;
               end
            end
            if (etu_end && idx == 4'd13 && rpt) begin
               sub  <= '0;
               idx  <= '0;
               rpt  <= 1'b0;
               rcnt <= rcnt + 1'b1;
            end
         end
      end
   end

   a_r6_fail_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> done);
   a_r6_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (rcnt <= max_retry));
   a_r2_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> drv);
endmodule

// File: rtl/scc_rx.sv
module scc_rx
   import scc_pkg::*;
#(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [DIV_W-1:0] div,
   input  logic             msb_first,
   input  logic             invert,
   input  logic             odd_par,
   input  logic             line_s,
   input  logic             tx_hold,
   output logic             busy,
   output logic             drv,
   output logic             valid,
   output logic [7:0]       data,
   output logic             perr
);
   logic             busy_q, bad, line_prev;
   logic [DIV_W-1:0] sub;
   logic [3:0]       idx;
   logic [7:0]       sh, dat_log;
   logic             mid, etu_end, par_ok;

   assign mid     = tick && (sub == (div >> 1));
   assign etu_end = tick && (sub == (div - 1'b1));
   assign dat_log = (msb_first ? scc_rev8(sh) : sh) ^ {8{invert}};
   assign par_ok  = ((^dat_log) ^ line_s ^ invert) == odd_par;
   assign busy    = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0; bad <= 1'b0; line_prev <= 1'b1;
         sub <= '0; idx <= '0; sh <= '0;
         drv <= 1'b0; valid <= 1'b0; data <= '0; perr <= 1'b0;
      end else begin
         line_prev <= line_s;
         valid     <= 1'b0;
         perr      <= 1'b0;
         if (!busy_q) begin
            if (!tx_hold && line_prev && !line_s) begin
               busy_q <= 1'b1; sub <= '0; idx <= '0; bad <= 1'b0;
            end
         end else if (tick) begin
            if (etu_end) begin
               sub <= '0;
               idx <= idx + 4'd1;
            end else begin
               sub <= sub + 1'b1;
            end
            if (mid) begin
               if (idx == 4'd0 && line_s) busy_q <= 1'b0;
               if (idx >= 4'd1 && idx <= 4'd8) sh <= {line_s, sh[7:1]};
               if (idx == 4'd9) begin
                  if (par_ok) begin
                     valid <= 1'b1;
                     data  <= dat_log;
                  end else begin
                     perr <= 1'b1;
                     bad  <= 1'b1;
                  end
               end
               if (idx == 4'd10 && bad) drv <= 1'b1;
               if (idx == 4'd11) drv <= 1'b0;
            end
            if (tick && sub == '0 && idx == 4'd12) busy_q <= 1'b0;
         end
      end
   end

   a_r10_no_valid_with_error: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid && perr));
   a_r10_drive_only_after_error: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv) |-> bad);
endmodule

// File: rtl/scc_xcvr.sv
module scc_xcvr #(
   parameter int DIV_W       = 12,
   parameter int RETRY_W     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_tick,
   input  logic [DIV_W-1:0]   etu_div,
   input  logic               cfg_msb_first,
   input  logic               cfg_invert,
   input  logic               cfg_odd_par,
   input  logic               cfg_tend_early,
   input  logic               cfg_clk_en,
   input  logic [RETRY_W-1:0] max_retry,
   input  logic               tx_valid,
   input  logic [7:0]         tx_data,
   output logic               tx_ready,
   output logic               tx_done,
   output logic               tx_fail,
   output logic               rx_valid,
   output logic [7:0]         rx_data,
   output logic               rx_par_err,
   input  logic               line_in,
   output logic               line_drive_low,
   output logic               card_clk
);
   generate
      if (DIV_W < 3) begin : g_bad_div
         $error("DIV_W must be at least 3");
      end
      if (RETRY_W < 1) begin : g_bad_retry
         $error("RETRY_W must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic line_s, tx_busy, rx_busy, tx_drv, rx_drv;

   scc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s));

   scc_tx #(.DIV_W(DIV_W), .RETRY_W(RETRY_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(bit_tick), .div(etu_div),
      .msb_first(cfg_msb_first), .invert(cfg_invert), .odd_par(cfg_odd_par),
      .tend_early(cfg_tend_early), .max_retry(max_retry), .line_s(line_s),
      .rx_busy(rx_busy), .valid(tx_valid), .data(tx_data), .ready(tx_ready),
      .busy(tx_busy), .drv(tx_drv), .done(tx_done), .fail(tx_fail));

   scc_rx #(.DIV_W(DIV_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(bit_tick), .div(etu_div),
      .msb_first(cfg_msb_first), .invert(cfg_invert), .odd_par(cfg_odd_par),
      .line_s(line_s), .tx_hold(tx_busy | tx_valid), .busy(rx_busy),
      .drv(rx_drv), .valid(rx_valid), .data(rx_data), .perr(rx_par_err));

   scc_cardclk u_clk (
      .clk(clk), .rst_n(rst_n), .tick(bit_tick), .en(cfg_clk_en),
      .card_clk(card_clk));

   assign line_drive_low = tx_drv | rx_drv;

   a_r13_half_duplex: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_busy && rx_busy));
   a_r2_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
      etu_div >= 4);
endmodule

// File: tb/sim_scc_xcvr.sv
`timescale 1ns/1ps
module sim_scc_xcvr;
   localparam int D = 16;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, bit_tick, cfg_msb_first, cfg_invert, cfg_odd_par;
   logic cfg_tend_early, cfg_clk_en, tx_valid, card_low;
   logic [11:0] etu_div;
   logic [1:0]  max_retry;
   logic [7:0]  tx_data, rx_data;
   logic tx_ready, tx_done, tx_fail, rx_valid, rx_par_err, line_drive_low, card_clk;
   logic line;
   assign line = ~(line_drive_low | card_low);

   scc_xcvr u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .etu_div(etu_div),
      .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
      .cfg_odd_par(cfg_odd_par), .cfg_tend_early(cfg_tend_early),
      .cfg_clk_en(cfg_clk_en), .max_retry(max_retry), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_ready(tx_ready), .tx_done(tx_done),
      .tx_fail(tx_fail), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_par_err(rx_par_err), .line_in(line),
      .line_drive_low(line_drive_low), .card_clk(card_clk));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int errors = 0, checks = 0;
   logic [9:0] exp_q[$];
   logic [7:0] rx_q[$];
   int starts[$];
   int inj_err = 0, perr_seen = 0, stray_rx = 0;
   bit rx_mode = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // line levels, index 0 = start bit, 1..8 data in wire order, 9 parity
   function automatic logic [9:0] enc(input logic [7:0] b, input bit msb,
                                      input bit inv, input bit odd);
      logic [9:0] r;
      r[0] = 1'b0;
      for (int i = 0; i < 8; i++) r[1+i] = (msb ? b[7-i] : b[i]) ^ inv;
      r[9] = (^b) ^ odd ^ inv;
      return r;
   endfunction

   // transmit monitor: decodes frames on the line, injects card error signals
   initial begin : tx_mon
      logic [9:0] raw;
      logic [9:0] e;
      forever begin
         @(negedge clk);
         if (rst_n && line_drive_low && !rx_mode) begin
            starts.push_back(cyc);
            repeat (D/2) @(negedge clk);
            raw[0] = line;
            for (int k = 1; k < 10; k++) begin
               repeat (D) @(negedge clk);
               raw[k] = line;
            end
            if (inj_err > 0) begin
               repeat (D) @(negedge clk);
               card_low = 1'b1;
               repeat (D) @(negedge clk);
               card_low = 1'b0;
               inj_err--;
            end
            if (exp_q.size() == 0) chk(0, "R2", "unexpected frame", int'(raw), 0);
            else begin
               e = exp_q.pop_front();
               chk(raw == e, "R2 R3 R4 R5", "frame levels", int'(raw), int'(e));
            end
            while (line_drive_low) @(negedge clk);
         end
      end
   end

   // receive monitor
   initial begin : rx_mon
      logic [7:0] e;
      forever begin
         @(negedge clk);
         if (rx_valid || rx_par_err) if (!rx_mode) stray_rx++;
         if (rx_par_err) perr_seen++;
         if (rx_valid) begin
            if (rx_q.size() == 0) chk(0, "R9 R13", "unexpected rx_valid", rx_data, 0);
            else begin
               e = rx_q.pop_front();
               chk(rx_data == e, "R9", "received byte", rx_data, e);
            end
         end
      end
   end

   task automatic send_tx(input logic [7:0] b, input int nfr, input bit exp_fail,
                          input int lat);
      int dc;
      for (int i = 0; i < nfr; i++)
         exp_q.push_back(enc(b, cfg_msb_first, cfg_invert, cfg_odd_par));
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b1; tx_data = b;
      @(negedge clk);
      tx_valid = 1'b0;
      while (!tx_done) @(negedge clk);
      dc = cyc;
      chk(tx_fail == exp_fail, "R6", "tx_fail at done", tx_fail, exp_fail);
      chk(dc - starts[$] == lat, "R7", "done latency", dc - starts[$], lat);
      chk(exp_q.size() == 0, "R6", "frames left", exp_q.size(), 0);
   endtask

   task automatic send_rx(input logic [7:0] b, input bit bad);
      logic [9:0] raw;
      int p0;
      rx_mode = 1;
      p0 = perr_seen;
      raw = enc(b, cfg_msb_first, cfg_invert, cfg_odd_par);
      if (bad) raw[9] = ~raw[9];
      else rx_q.push_back(b);
      @(negedge clk);
      for (int k = 0; k < 10; k++) begin
         card_low = ~raw[k];
         repeat (D) @(negedge clk);
      end
      card_low = 1'b0;
      repeat (D) @(negedge clk);
      chk(line_drive_low == bad, "R10", "error signal at 11 etu", line_drive_low, bad);
      repeat (3*D) @(negedge clk);
      chk(perr_seen - p0 == int'(bad), "R10", "parity error pulses", perr_seen - p0, bad);
      chk(rx_q.size() == 0, "R9", "bytes not received", rx_q.size(), 0);
      rx_mode = 0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      logic a, b2;
      int p0;
      rst_n = 0; bit_tick = 1; etu_div = 12'(D); cfg_msb_first = 0; cfg_invert = 0;
      cfg_odd_par = 0; cfg_tend_early = 0; cfg_clk_en = 0; max_retry = 2'd3;
      tx_valid = 0; tx_data = '0; card_low = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(tx_ready == 1, "R1", "tx_ready", tx_ready, 1);
      chk(line_drive_low == 0, "R1", "line_drive_low", line_drive_low, 0);
      chk(card_clk == 0, "R1", "card_clk", card_clk, 0);
      chk(!rx_valid && !rx_par_err && !tx_done, "R1", "pulses idle",
          {rx_valid, rx_par_err, tx_done}, 0);

      // R12 card clock
      repeat (8) @(negedge clk);
      chk(card_clk == 0, "R12", "clock held low", card_clk, 0);
      cfg_clk_en = 1;
      repeat (3) @(negedge clk);
      a = card_clk; @(negedge clk); b2 = card_clk;
      chk(a != b2, "R12", "clock toggles", b2, ~a);
      cfg_clk_en = 0;
      repeat (2) @(negedge clk);
      chk(card_clk == 0, "R12", "clock off again", card_clk, 0);

      // R2 R4 R5 direct convention, 0x3B, normal done timing
      chk(enc(8'h3B, 0, 0, 0) == 10'b1001110110, "R4", "0x3B direct levels",
          int'(enc(8'h3B, 0, 0, 0)), 10'b1001110110);
      send_tx(8'h3B, 1, 0, 12*D + 1);

      // R3 R4 inverse convention, early done timing, then guard R8
      cfg_msb_first = 1; cfg_invert = 1; cfg_tend_early = 1;
      send_tx(8'h3F, 1, 0, 11*D + 1);
      chk(tx_ready == 0, "R8", "ready low in guard", tx_ready, 0);
      send_tx(8'hA5, 1, 0, 11*D + 1);
      chk(starts[$] - starts[$-1] >= 12*D, "R8", "start spacing",
          starts[$] - starts[$-1], 12*D);
      cfg_tend_early = 0;

      // R3 R4 controls used separately
      cfg_msb_first = 1; cfg_invert = 0;
      send_tx(8'h12, 1, 0, 12*D + 1);
      cfg_msb_first = 0; cfg_invert = 1;
      send_tx(8'h12, 1, 0, 12*D + 1);

      // R5 odd parity
      cfg_invert = 0; cfg_odd_par = 1;
      send_tx(8'h00, 1, 0, 12*D + 1);
      send_tx(8'h80, 1, 0, 12*D + 1);
      cfg_odd_par = 0;

      // R6 single error signal then resend
      inj_err = 1;
      send_tx(8'h55, 2, 0, 12*D + 1);
      chk(starts[$] - starts[$-1] == 14*D, "R6", "resend spacing",
          starts[$] - starts[$-1], 14*D);

      // R6 retries used up
      max_retry = 2'd1; inj_err = 2;
      send_tx(8'hC3, 2, 1, 12*D + 1);
      max_retry = 2'd3;
      chk(stray_rx == 0, "R13", "receiver quiet during transmit", stray_rx, 0);

      // R9 receive in several conventions
      repeat (2*D) @(negedge clk);
      send_rx(8'h3B, 0);
      cfg_msb_first = 1; cfg_invert = 1;
      send_rx(8'h3F, 0);
      cfg_msb_first = 0; cfg_invert = 0; cfg_odd_par = 1;
      send_rx(8'h6E, 0);
      cfg_odd_par = 0;

      // R10 bad parity
      send_rx(8'h47, 1);

      // R11 glitch on the start bit
      rx_mode = 1;
      p0 = perr_seen;
      @(negedge clk);
      card_low = 1;
      repeat (3) @(negedge clk);
      card_low = 0;
      repeat (14*D) @(negedge clk);
      chk(perr_seen == p0 && line_drive_low == 0, "R11", "glitch ignored",
          perr_seen - p0, 0);
      send_rx(8'hD2, 0);

      chk(exp_q.size() == 0 && rx_q.size() == 0, "R9", "queues drained",
          exp_q.size() + rx_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule